// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers interrupt requests from two external pins, two timer overflow events and a serial port, and decides when one of them may interrupt the processor. Each source has its own enable bit. A global enable gates all of them. A priority bit puts each source at the low or the high level. Each external pin has a trigger-type bit that selects falling-edge or level sensing.

The processor tells the controller when an instruction is in its final machine cycle. It also flags instructions that write the enable or priority configuration, and it strobes a return-from-interrupt. When a request is accepted, the controller pulses `irq_take` together with the vector address of the source, and marks the level as being served. It also pulses hardware clears for the flag that the handler consumes. A return strobe releases the innermost active level. Stacking the program counter and running the handler belong to the processor, not to this block.

Top module: `irq2_ctrl`

## Requirements
- R1: A source is accepted only when its bit in `src_en` and `glob_en` are both 1.
- R2: A high-level request is accepted while only a low-level handler runs. No request is accepted while a high-level handler runs. A low-level request is accepted only when no level is active.
- R3: Acceptance happens only on a clock edge where `last_cycle` is 1 and both `cfg_wr` and `reti` are 0.
- R4: The high level is chosen before the low level. Within a level, the lowest source index wins. Source indices are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial.
- R5: On the edge that accepts source n, `irq_take` goes to 1 for one cycle. In the same cycle `irq_vec` = 0x0003 + 8*n and `irq_lvl_hi` gives the accepted level. In all other cycles `irq_take`, `irq_vec` and `irq_lvl_hi` are 0.
- R6: A `reti` strobe clears `act_hi` if it is set, and otherwise clears `act_lo`.
- R7: Flag positions are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial transmit, 5 serial receive. Accepting a timer, or an external pin in edge mode, clears that flag and pulses the same bit of `hw_clr`. Serial flags and level-mode external flags are never cleared by acceptance.
- R8: For an external pin in edge mode (`trig_edge` bit = 1), a falling edge of the pin or a `flag_set` write sets the flag one cycle later. `flag_clr` clears it.
- R9: For an external pin in level mode (`trig_edge` bit = 0), the flag equals the inverted pin value of the previous cycle. `flag_set` and `flag_clr` have no effect.
- R10: A timer or serial flag is set by its event input or by `flag_set`, and cleared by `flag_clr` (and by acceptance, for timers). A set in the same cycle wins over any clear.
- R11: After reset all flags, active levels and output pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin_n | input | 2 | External request pins, active low, already synchronized |
| trig_edge | input | 2 | Per pin: 1 selects falling-edge sensing, 0 selects level sensing |
| tmr_ovf | input | 2 | Timer overflow event pulses |
| ser_tx_done | input | 1 | Serial transmit complete pulse |
| ser_rx_done | input | 1 | Serial receive complete pulse |
| flag_set | input | 6 | Software set strobes, one per flag |
| flag_clr | input | 6 | Software clear strobes, one per flag |
| src_en | input | 5 | Per-source enable |
| glob_en | input | 1 | Global enable |
| src_hi | input | 5 | Per-source level: 1 high, 0 low |
| last_cycle | input | 1 | Current cycle is the final machine cycle of an instruction |
| cfg_wr | input | 1 | Current instruction writes the enable or priority configuration |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_take | output | 1 | Acceptance pulse |
| irq_vec | output | 16 | Vector address of the accepted source |
| irq_lvl_hi | output | 1 | Accepted request is at the high level |
| act_hi | output | 1 | High-level handler in service |
| act_lo | output | 1 | Low-level handler in service |
| flags | output | 6 | Request flags |
| hw_clr | output | 6 | One-cycle hardware clear pulses per flag |

## Verification
The bench attacks nesting. It takes a low-level request, offers a second low request and then a high one, and offers another high request while the high handler runs. A controller with the wrong level comparison would either nest a request at the same level or let a request interrupt a high handler. It unwinds with two returns, which catches a design that releases the wrong level. It also holds requests pending while `last_cycle` is 0, `cfg_wr` is 1 or `reti` is 1, which exposes a design that accepts in the middle of an instruction. Level-mode pins, serial flags that survive acceptance, and set winning over clear in the same cycle each get their own cases. A design that clears the wrong flag, or honours software writes to a level-mode flag, shows a wrong `flags` value there.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
    localparam int NEXT   = 2;
    localparam int NTMR   = 2;
    localparam int NSRC   = NEXT + NTMR + 1;
    localparam int NFLAG  = NEXT + NTMR + 2;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int VEC_W  = 16;
    localparam int FL_TX  = NEXT + NTMR;
    localparam int FL_RX  = NEXT + NTMR + 1;

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             lvl_hi;
        logic             act_hi;
        logic             act_lo;
        logic [NFLAG-1:0] hw_clr;
    } ctrl_st_t;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NEXT-1:0]  pin_prev;
    } flag_st_t;
endpackage

// File: rtl/irq2_pick.sv
module irq2_pick #(
    parameter int N = 5,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/irq2_flags.sv
module irq2_flags
    import irq2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NEXT-1:0]  ext_pin_n,
    input  logic [NEXT-1:0]  trig_edge,
    input  logic [NTMR-1:0]  tmr_ovf,
    input  logic             ser_tx_done,
    input  logic             ser_rx_done,
    input  logic [NFLAG-1:0] flag_set,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] hw_clr,
    output logic [NFLAG-1:0] flags
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pin_prev = ext_pin_n;
        // external pins sit at even flag positions
        for (int j = 0; j < NEXT; j++) begin
            if (trig_edge[j]) begin
                if ((st_q.pin_prev[j] & ~ext_pin_n[j]) | flag_set[2*j])
                    st_d.flags[2*j] = 1'b1;
                else if (hw_clr[2*j] | flag_clr[2*j])
                    st_d.flags[2*j] = 1'b0;
            end else begin
                st_d.flags[2*j] = ~ext_pin_n[j];
            end
        end
        // timers sit at odd flag positions
        for (int j = 0; j < NTMR; j++) begin
            if (tmr_ovf[j] | flag_set[2*j+1])
                st_d.flags[2*j+1] = 1'b1;
            else if (hw_clr[2*j+1] | flag_clr[2*j+1])
                st_d.flags[2*j+1] = 1'b0;
        end
        // serial flags: software clear only
        if (ser_tx_done | flag_set[FL_TX])  st_d.flags[FL_TX] = 1'b1;
        else if (flag_clr[FL_TX])           st_d.flags[FL_TX] = 1'b0;
        if (ser_rx_done | flag_set[FL_RX])  st_d.flags[FL_RX] = 1'b1;
        else if (flag_clr[FL_RX])           st_d.flags[FL_RX] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags    <= '0;
            st_q.pin_prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
    import irq2_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
    parameter logic [VEC_W-1:0] VEC_STEP = 16'h0008
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ext_pin_n,
    input  logic [1:0]  trig_edge,
    input  logic [1:0]  tmr_ovf,
    input  logic        ser_tx_done,
    input  logic        ser_rx_done,
    input  logic [5:0]  flag_set,
    input  logic [5:0]  flag_clr,
    input  logic [4:0]  src_en,
    input  logic        glob_en,
    input  logic [4:0]  src_hi,
    input  logic        last_cycle,
    input  logic        cfg_wr,
    input  logic        reti,
    output logic        irq_take,
    output logic [15:0] irq_vec,
    output logic        irq_lvl_hi,
    output logic        act_hi,
    output logic        act_lo,
    output logic [5:0]  flags,
    output logic [5:0]  hw_clr
);
    ctrl_st_t         st_d, st_q;
    logic [NSRC-1:0]  req, elig;
    logic [1:0]       lv_any;
    logic [SRC_W-1:0] lv_idx [2];
    logic             pick_hi, pick_ok, accept;
    logic [SRC_W-1:0] sel_idx;
    logic [NFLAG-1:0] clr_now;

    irq2_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin_n  (ext_pin_n),
        .trig_edge  (trig_edge),
        .tmr_ovf    (tmr_ovf),
        .ser_tx_done(ser_tx_done),
        .ser_rx_done(ser_rx_done),
        .flag_set   (flag_set),
        .flag_clr   (flag_clr),
        .hw_clr     (clr_now),
        .flags      (flags)
    );

    always_comb begin
        for (int k = 0; k < NEXT + NTMR; k++) req[k] = flags[k];
        req[NSRC-1] = flags[FL_TX] | flags[FL_RX];
        elig = req & src_en & {NSRC{glob_en}};
    end

    // one fixed-order finder per level; index 1 is the high level
    for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
        irq2_pick #(.N(NSRC)) u_pick (
            .bits(elig & ((lv == 1) ? src_hi : ~src_hi)),
            .any (lv_any[lv]),
            .idx (lv_idx[lv])
        );
    end

    always_comb begin
        pick_hi = lv_any[1] & ~st_q.act_hi;
        pick_ok = pick_hi | (lv_any[0] & ~st_q.act_hi & ~st_q.act_lo);
        sel_idx = pick_hi ? lv_idx[1] : lv_idx[0];
        accept  = last_cycle & ~cfg_wr & ~reti & pick_ok;

        clr_now = '0;
        for (int k = 0; k < NEXT + NTMR; k++) begin
            if (accept && sel_idx == SRC_W'(k) && ((k % 2) == 1 || trig_edge[k/2]))
                clr_now[k] = 1'b1;
        end

        st_d        = st_q;
        st_d.take   = accept;
        st_d.vec    = accept ? (VEC_W'(sel_idx) * VEC_STEP + VEC_BASE) : '0;
        st_d.lvl_hi = accept & pick_hi;
        st_d.hw_clr = clr_now;
        if (reti) begin
            if (st_q.act_hi) st_d.act_hi = 1'b0;
            else             st_d.act_lo = 1'b0;
        end
        if (accept) begin
            if (pick_hi) st_d.act_hi = 1'b1;
            else         st_d.act_lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_take   = st_q.take;
    assign irq_vec    = st_q.vec;
    assign irq_lvl_hi = st_q.lvl_hi;
    assign act_hi     = st_q.act_hi;
    assign act_lo     = st_q.act_lo;
    assign hw_clr     = st_q.hw_clr;
endmodule

// File: rtl/irq2_chk.sv
module irq2_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       last_cycle,
    input logic       cfg_wr,
    input logic       reti,
    input logic       glob_en,
    input logic [1:0] trig_edge,
    input logic [1:0] ext_pin_n,
    input logic [1:0] ext_flags,
    input logic [1:0] ser_flags,
    input logic [1:0] ser_clr,
    input logic       irq_take,
    input logic       irq_lvl_hi,
    input logic       act_hi,
    input logic       act_lo,
    input logic [5:0] hw_clr
);
    assert_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(glob_en));

    assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(last_cycle && !cfg_wr && !reti));

    assert_hi_not_nested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !$past(act_hi));

    assert_lo_needs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !irq_lvl_hi) |-> !$past(act_lo));

    assert_hi_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_hi) |-> (irq_take && irq_lvl_hi));

    assert_one_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hw_clr));

    for (genvar s = 0; s < 2; s++) begin : g_ser
        assert_ser_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ser_flags[s]) |-> $past(ser_clr[s]));
    end

    for (genvar j = 0; j < 2; j++) begin : g_lvl
        assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !trig_edge[j] && !$past(trig_edge[j]))
                |-> (ext_flags[j] == !$past(ext_pin_n[j])));
    end
endmodule

bind irq2_ctrl irq2_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_cycle(last_cycle),
    .cfg_wr    (cfg_wr),
    .reti      (reti),
    .glob_en   (glob_en),
    .trig_edge (trig_edge),
    .ext_pin_n (ext_pin_n),
    .ext_flags ({flags[2], flags[0]}),
    .ser_flags (flags[5:4]),
    .ser_clr   (flag_clr[5:4]),
    .irq_take  (irq_take),
    .irq_lvl_hi(irq_lvl_hi),
    .act_hi    (act_hi),
    .act_lo    (act_lo),
    .hw_clr    (hw_clr)
);

// File: tb/irq2_ctrl_test.sv
`timescale 1ns/1ps
module irq2_ctrl_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] ext_pin_n = 2'b11, trig_edge = 2'b11, tmr_ovf = '0;
    logic ser_tx_done = 1'b0, ser_rx_done = 1'b0;
    logic [5:0] flag_set = '0, flag_clr = '0;
    logic [4:0] src_en = 5'h1f, src_hi = '0;
    logic glob_en = 1'b1, last_cycle = 1'b0, cfg_wr = 1'b0, reti = 1'b0;
    logic irq_take, irq_lvl_hi, act_hi, act_lo;
    logic [15:0] irq_vec;
    logic [5:0] flags, hw_clr;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq2_ctrl uut (.*);

    // behavioural reference model
    logic [5:0] m_flags, m_clr;
    logic [1:0] m_prev;
    logic m_hi, m_lo, m_take, m_lvl;
    logic [15:0] m_vec;

    always @(posedge clk) begin : model
        logic [4:0] req, el;
        logic [5:0] nf;
        int hc, lc, c;
        bit chi, acc;
        if (!rst_n) begin
            m_flags = '0; m_clr = '0; m_prev = 2'b11;
            m_hi = 0; m_lo = 0; m_take = 0; m_lvl = 0; m_vec = '0;
        end else begin
            req = {m_flags[4] | m_flags[5], m_flags[3:0]};
            el  = glob_en ? (req & src_en) : 5'd0;
            hc = -1; lc = -1;
            for (int i = 4; i >= 0; i--) begin
                if (el[i] && src_hi[i])  hc = i;
                if (el[i] && !src_hi[i]) lc = i;
            end
            c = -1; chi = 0;
            if (!m_hi && hc >= 0) begin c = hc; chi = 1; end
            else if (!m_hi && !m_lo && lc >= 0) c = lc;
            acc = last_cycle && !cfg_wr && !reti && (c >= 0);
            nf = m_flags; m_clr = '0;
            for (int j = 0; j < 2; j++) begin
                if (trig_edge[j]) begin
                    if ((m_prev[j] && !ext_pin_n[j]) || flag_set[2*j]) nf[2*j] = 1;
                    else if ((acc && c == 2*j) || flag_clr[2*j]) nf[2*j] = 0;
                    if (acc && c == 2*j) m_clr[2*j] = 1;
                end else nf[2*j] = !ext_pin_n[j];
                if (tmr_ovf[j] || flag_set[2*j+1]) nf[2*j+1] = 1;
                else if ((acc && c == 2*j+1) || flag_clr[2*j+1]) nf[2*j+1] = 0;
                if (acc && c == 2*j+1) m_clr[2*j+1] = 1;
            end
            if (ser_tx_done || flag_set[4]) nf[4] = 1; else if (flag_clr[4]) nf[4] = 0;
            if (ser_rx_done || flag_set[5]) nf[5] = 1; else if (flag_clr[5]) nf[5] = 0;
            m_prev = ext_pin_n; m_flags = nf;
            m_take = acc; m_lvl = acc && chi;
            m_vec = acc ? 16'(3 + 8 * c) : 16'd0;
            if (reti) begin if (m_hi) m_hi = 0; else m_lo = 0; end
            if (acc) begin if (chi) m_hi = 1; else m_lo = 1; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 take/vector/level", {irq_take, irq_lvl_hi, irq_vec}, {m_take, m_lvl, m_vec});
            chk("R2 active levels", {act_hi, act_lo}, {m_hi, m_lo});
            chk("R7 hw clear pulses", hw_clr, m_clr);
            chk("R10 flags", flags, m_flags);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R11 reset outputs", {irq_take, act_hi, act_lo, flags, hw_clr, irq_vec}, 0);

        // R1 masking
        glob_en = 0; tmr_ovf[0] = 1; tick(); tmr_ovf[0] = 0;
        chk("R10 timer event sets flag", flags[1], 1);
        last_cycle = 1; tick();
        chk("R1 global mask blocks", irq_take, 0);
        glob_en = 1; src_en = 5'h1d; tick();
        chk("R1 source mask blocks", irq_take, 0);
        src_en = 5'h1f; tick();
        chk("R5 timer0 vector", {irq_take, irq_vec}, {1'b1, 16'h000b});
        chk("R7 timer0 hw clear", {hw_clr, flags[1]}, {6'b000010, 1'b0});
        last_cycle = 0; reti = 1; tick(); reti = 0;
        chk("R6 release low", {act_hi, act_lo}, 0);

        // R3 acceptance window
        flag_set[3] = 1; tick(); flag_set = 0;
        tick();
        chk("R3 mid-instruction blocked", irq_take, 0);
        last_cycle = 1; cfg_wr = 1; tick();
        chk("R3 config write blocked", irq_take, 0);
        cfg_wr = 0; reti = 1; tick();
        chk("R3 return blocked", irq_take, 0);
        reti = 0; tick();
        chk("R3 accepted in window", {irq_take, irq_vec}, {1'b1, 16'h001b});
        last_cycle = 0; reti = 1; tick(); reti = 0;

        // R4 fixed order at one level
        flag_set = 6'b011100; tick(); flag_set = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R4 external1 first", irq_vec, 16'h0013);
        reti = 1; tick(); reti = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R4 timer1 next", irq_vec, 16'h001b);
        reti = 1; tick(); reti = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R4 serial last", irq_vec, 16'h0023);
        chk("R7 serial flag survives", flags[4], 1);
        reti = 1; tick(); reti = 0;
        flag_clr[4] = 1; tick(); flag_clr = 0;
        chk("R10 serial software clear", flags[4], 0);
        flag_set[5] = 1; flag_clr[5] = 1; tick(); flag_set = 0; flag_clr = 0;
        chk("R10 set wins over clear", flags[5], 1);
        flag_clr[5] = 1; tick(); flag_clr = 0;

        // R2 nesting
        src_hi = 5'b01000;
        flag_set[1] = 1; tick(); flag_set = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R2 low accepted", {irq_take, irq_lvl_hi, act_lo}, 3'b101);
        flag_set[0] = 1; tick(); flag_set = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R2 equal level not nested", irq_take, 0);
        flag_set[3] = 1; tick(); flag_set = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R2 high preempts low", {irq_take, irq_lvl_hi, irq_vec}, {2'b11, 16'h001b});
        flag_set[3] = 1; tick(); flag_set = 0;
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R2 high not preempted", irq_take, 0);
        reti = 1; tick();
        chk("R6 release high first", {act_hi, act_lo}, 2'b01);
        tick(); reti = 0;
        chk("R6 release low second", {act_hi, act_lo}, 2'b00);
        flag_clr = 6'b001001; src_hi = 0; tick(); flag_clr = 0;

        // R8 edge mode
        ext_pin_n[0] = 0; tick();
        chk("R8 falling edge sets", flags[0], 1);
        ext_pin_n[0] = 1; tick();
        chk("R8 flag holds after edge", flags[0], 1);
        flag_clr[0] = 1; tick(); flag_clr = 0;
        chk("R8 software clear", flags[0], 0);

        // R9 level mode
        trig_edge[1] = 0; ext_pin_n[1] = 0; tick();
        chk("R9 follows pin low", flags[2], 1);
        flag_clr[2] = 1; tick(); flag_clr = 0;
        chk("R9 software clear ignored", flags[2], 1);
        ext_pin_n[1] = 1; flag_set[2] = 1; tick(); flag_set = 0;
        chk("R9 software set ignored", flags[2], 0);
        ext_pin_n[1] = 0; tick();
        last_cycle = 1; tick(); last_cycle = 0;
        chk("R7 level source not cleared", {irq_take, hw_clr, flags[2]}, {1'b1, 6'b0, 1'b1});
        ext_pin_n[1] = 1; reti = 1; tick(); reti = 0;
        tick(2);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule